// File: doc/BRIEF.md
# Timer Tick Source Selector and Prescaler

This block is the clock front end of a general-purpose timer. It decides which event advances the counter prescaler. The choice depends on two 3-bit codes: a slave-mode code and a trigger-select code. The possible sources are the internal timer clock, a synchronized edge on one of two external channel pins, or a rising edge on one of four internal trigger lines. Some slave-mode codes force the internal clock whatever the trigger-select value.

The selected tick feeds a 16-bit prescaler that divides by (value + 1). A new prescaler value waits in a shadow and is loaded only at an update event. The prescaler output is a single-cycle counter strobe. That strobe drives an up-counter, which wraps to zero at a reload value. Each wrap, and each software update request, raises a one-cycle update event.

Top module: `tmr_tick_front`

## Requirements
- R1: With `slave_mode` = 0, a prescaler value of 0 and `cnt_en` high, `cnt_val` increases by one on every clock edge.
- R2: With `slave_mode` = 4, 5 or 6, the internal clock drives the prescaler whatever the value of `trig_sel`.
- R3: With `slave_mode` = 1, 2, 3 or 7 and `trig_sel` = n (0..3), a rising edge on `itrig_in[n]` gives one tick. A falling edge on that line gives none. Activity on the other trigger lines gives none.
- R4: With `slave_mode` in {1,2,3,7} and `trig_sel` = 4, both the rising and the falling edges of `ch0_in` give a tick.
- R5: With `trig_sel` = 5 the tick source is `ch0_in`, and with `trig_sel` = 6 it is `ch1_in`. In both cases the matching polarity bit selects the edge: 0 for a rising edge, 1 for a falling edge. The other channel is ignored.
- R6: With `slave_mode` in {1,2,3,7} and `trig_sel` = 7, no tick is produced and the counter holds.
- R7: External and trigger inputs pass through two synchronizer flops and then an edge detector. After an input changes, the counter (prescaler 0) has not yet moved at the second rising clock edge and has advanced at the third.
- R8: While `cnt_en` is low, neither the prescaler nor the counter advances.
- R9: With an active prescaler value P, `cnt_tick` pulses once per P+1 selected ticks, and the counter advances once per pulse.
- R10: A new `psc_val` takes effect only after an update event. Until then the previous division stays in force.
- R11: When a counter strobe occurs with `cnt_val` equal to `reload_val`, the counter goes to 0 and `upd_evt` is high for exactly the next cycle.
- R12: `upd_gen` held high for one cycle clears the counter and restarts the prescaler at that edge, and raises `upd_evt` for the following cycle.
- R13: After synchronous reset, `cnt_val` is 0, `upd_evt` is 0 and `cnt_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable; prescaler runs only while high |
| slave_mode | input | 3 | Slave-mode code |
| trig_sel | input | 3 | Trigger-select code |
| ch0_pol | input | 1 | Channel 0 edge polarity (0 rising, 1 falling) |
| ch1_pol | input | 1 | Channel 1 edge polarity (0 rising, 1 falling) |
| ch0_in | input | 1 | External channel 0 input, asynchronous |
| ch1_in | input | 1 | External channel 1 input, asynchronous |
| itrig_in | input | 4 | Internal trigger lines, asynchronous |
| psc_val | input | 16 | Prescaler shadow value, loaded at update |
| reload_val | input | 16 | Counter reload value |
| upd_gen | input | 1 | Software update request |
| cnt_tick | output | 1 | Counter clock-enable strobe |
| cnt_val | output | 16 | Counter value |
| upd_evt | output | 1 | One-cycle update event |

## Verification
On every cycle the assertions check the following. Detected edges last a single cycle. The prescaler count never passes its active limit. Prescaler and counter hold while they are not enabled or not ticked. Each update event comes with a zero count, and a software update clears the counter and raises the event. Only the directed scenarios can show which source each slave-mode and trigger-select pairing actually chooses, the edge polarities, the three-edge input latency, the division ratio, and that a new prescaler value waits for an update.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    // Trigger-select index width picks how many internal triggers exist
    localparam int TSEL_IDX_W = 2;
    localparam int ITRIG_N    = 1 << TSEL_IDX_W;
    localparam int CH_N       = 2;
    localparam int LINE_N     = ITRIG_N + CH_N;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SRC_INTERNAL,
        SRC_TRIGGER,
        SRC_CHANNEL,
        SRC_NONE
    } src_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Slave-mode codes that hand the tick over to the trigger selector
    function automatic logic mode_uses_trigger(input logic [2:0] sm);
        return (sm == 3'd1) || (sm == 3'd2) || (sm == 3'd3) || (sm == 3'd7);
    endfunction

    function automatic src_kind_e decode_source(input logic [2:0] sm,
                                                input logic [2:0] ts);
        src_kind_e k;
        if (!mode_uses_trigger(sm))
            k = SRC_INTERNAL;
        else if (!ts[2])
            k = SRC_TRIGGER;
        else if (ts == 3'd7)
            k = SRC_NONE;
        else
            k = SRC_CHANNEL;
        return k;
    endfunction

    function automatic edge_t edges_of(input logic now_lvl, input logic old_lvl);
        edge_t e;
        e.rise = now_lvl & ~old_lvl;
        e.fall = ~now_lvl & old_lvl;
        return e;
    endfunction

endpackage

// File: rtl/tmr_sync_line.sv
module tmr_sync_line #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl_now,
    output logic lvl_old
);
    logic [DEPTH-1:0] sync_q;
    logic             hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[DEPTH-2:0], din};
            hist_q <= sync_q[DEPTH-1];
        end
    end

    assign lvl_now = sync_q[DEPTH-1];
    assign lvl_old = hist_q;

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_now && !lvl_old) |=> !(lvl_now && !lvl_old));

    // R7
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!lvl_now && lvl_old) |=> !(!lvl_now && lvl_old));

endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_tick_pkg::*;
(
    input  logic [2:0]        slave_mode,
    input  logic [2:0]        trig_sel,
    input  logic              ch0_pol,
    input  logic              ch1_pol,
    input  logic [LINE_N-1:0] lvl_now,
    input  logic [LINE_N-1:0] lvl_old,
    output logic              src_tick
);
    localparam int CH0_IDX = ITRIG_N;
    localparam int CH1_IDX = ITRIG_N + 1;

    edge_t [LINE_N-1:0] ev;
    logic  [ITRIG_N-1:0] trig_rise;

    for (genvar i = 0; i < LINE_N; i++) begin : g_edge
        assign ev[i] = edges_of(lvl_now[i], lvl_old[i]);
    end

    for (genvar i = 0; i < ITRIG_N; i++) begin : g_trig
        assign trig_rise[i] = ev[i].rise;
    end

    src_kind_e kind;
    assign kind = decode_source(slave_mode, trig_sel);

    always_comb begin
        src_tick = 1'b0;
        unique case (kind)
            SRC_INTERNAL: src_tick = 1'b1;
            SRC_TRIGGER:  src_tick = trig_rise[trig_sel[TSEL_IDX_W-1:0]];
            SRC_CHANNEL: begin
                unique case (trig_sel[1:0])
                    2'd0:    src_tick = ev[CH0_IDX].rise | ev[CH0_IDX].fall;
                    2'd1:    src_tick = ch0_pol ? ev[CH0_IDX].fall : ev[CH0_IDX].rise;
                    2'd2:    src_tick = ch1_pol ? ev[CH1_IDX].fall : ev[CH1_IDX].rise;
                    default: src_tick = 1'b0;
                endcase
            end
            default:      src_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             src_tick,
    input  logic             update,
    input  logic [PSC_W-1:0] psc_shadow,
    output logic             tick_out
);
    logic [PSC_W-1:0] div_cnt_q;
    logic [PSC_W-1:0] div_lim_q;
    logic             at_limit;

    assign at_limit = (div_cnt_q == div_lim_q);
    assign tick_out = en & src_tick & at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt_q <= '0;
            div_lim_q <= '0;
        end else if (update) begin
            div_cnt_q <= '0;
            div_lim_q <= psc_shadow;
        end else if (en && src_tick) begin
            div_cnt_q <= at_limit ? '0 : div_cnt_q + 1'b1;
        end
    end

    // R9
    div_bound_chk: assert property (@(posedge clk) disable iff (rst)
        div_cnt_q <= div_lim_q);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !update) |=> $stable(div_cnt_q));

    // R10
    lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !update |=> $stable(div_lim_q));

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             upd_gen,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             upd_evt,
    output logic             update
);
    logic [CNT_W-1:0] cnt_q;
    logic             evt_q;
    logic             wrap;

    assign wrap   = tick & (cnt_q == reload);
    assign update = upd_gen | wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= update;
            if (update)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign upd_evt = evt_q;

    // R11
    evt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        upd_evt |-> (cnt == '0));

    // R12
    swupd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        upd_gen |=> (cnt == '0) && upd_evt);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !upd_gen) |=> $stable(cnt) && !upd_evt);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !upd_gen && (cnt != reload)) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tmr_tick_front.sv
module tmr_tick_front
    import tmr_tick_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    input  logic [2:0]         slave_mode,
    input  logic [2:0]         trig_sel,
    input  logic               ch0_pol,
    input  logic               ch1_pol,
    input  logic               ch0_in,
    input  logic               ch1_in,
    input  logic [ITRIG_N-1:0] itrig_in,
    input  logic [PSC_W-1:0]   psc_val,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic               upd_gen,
    output logic               cnt_tick,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               upd_evt
);
    logic [LINE_N-1:0] raw_lines;
    logic [LINE_N-1:0] lvl_now;
    logic [LINE_N-1:0] lvl_old;
    logic              src_tick;
    logic              update;

    assign raw_lines = {ch1_in, ch0_in, itrig_in};

    for (genvar i = 0; i < LINE_N; i++) begin : g_sync
        tmr_sync_line #(.DEPTH(SYNC_DEPTH)) sync_i (
            .clk     (clk),
            .rst     (rst),
            .din     (raw_lines[i]),
            .lvl_now (lvl_now[i]),
            .lvl_old (lvl_old[i])
        );
    end

    tmr_src_sel sel_i (
        .slave_mode (slave_mode),
        .trig_sel   (trig_sel),
        .ch0_pol    (ch0_pol),
        .ch1_pol    (ch1_pol),
        .lvl_now    (lvl_now),
        .lvl_old    (lvl_old),
        .src_tick   (src_tick)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) psc_i (
        .clk        (clk),
        .rst        (rst),
        .en         (cnt_en),
        .src_tick   (src_tick),
        .update     (update),
        .psc_shadow (psc_val),
        .tick_out   (cnt_tick)
    );

    tmr_up_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick),
        .upd_gen (upd_gen),
        .reload  (reload_val),
        .cnt     (cnt_val),
        .upd_evt (upd_evt),
        .update  (update)
    );

    // R8
    no_strobe_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> !cnt_tick);

endmodule

// File: tb/tmr_tick_front_tb.sv
module tmr_tick_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [2:0]  slave_mode = 3'd0;
    logic [2:0]  trig_sel = 3'd0;
    logic        ch0_pol = 1'b0;
    logic        ch1_pol = 1'b0;
    logic        ch0_in = 1'b0;
    logic        ch1_in = 1'b0;
    logic [3:0]  itrig_in = 4'd0;
    logic [15:0] psc_val = 16'd0;
    logic [15:0] reload_val = 16'd1000;
    logic        upd_gen = 1'b0;
    logic        cnt_tick;
    logic [15:0] cnt_val;
    logic        upd_evt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_tick_front dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .slave_mode(slave_mode),
        .trig_sel(trig_sel), .ch0_pol(ch0_pol), .ch1_pol(ch1_pol),
        .ch0_in(ch0_in), .ch1_in(ch1_in), .itrig_in(itrig_in),
        .psc_val(psc_val), .reload_val(reload_val), .upd_gen(upd_gen),
        .cnt_tick(cnt_tick), .cnt_val(cnt_val), .upd_evt(upd_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Flush the synchronizers, then clear counter and load the prescaler
    task automatic restart();
        cnt_en = 1'b0;
        wait_cyc(4);
        upd_gen = 1'b1;
        wait_cyc(1);
        upd_gen = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset();
        chk(cnt_val == 0, "R13 cnt", cnt_val, 0);
        chk(upd_evt == 0, "R13 evt", upd_evt, 0);
        chk(cnt_tick == 0, "R13 tick", cnt_tick, 0);
    endtask

    task automatic t_internal();
        slave_mode = 3'd0; trig_sel = 3'd7; psc_val = 0; reload_val = 1000;
        restart();
        cnt_en = 1'b1;
        wait_cyc(5);
        chk(cnt_val == 5, "R1 internal count", cnt_val, 5);
    endtask

    task automatic t_forced_internal();
        for (int m = 4; m <= 6; m++) begin
            slave_mode = 3'(m); trig_sel = 3'(m - 2);
            restart();
            cnt_en = 1'b1;
            wait_cyc(4);
            chk(cnt_val == 4, "R2 forced internal", cnt_val, 4);
        end
    endtask

    task automatic t_itrig();
        slave_mode = 3'd1; trig_sel = 3'd2;
        restart();
        cnt_en = 1'b1;
        itrig_in = 4'b0010; wait_cyc(5);
        itrig_in = 4'b0000; wait_cyc(5);
        chk(cnt_val == 0, "R3 other trigger line ignored", cnt_val, 0);
        itrig_in = 4'b0100; wait_cyc(5);
        chk(cnt_val == 1, "R3 trigger rising edge", cnt_val, 1);
        itrig_in = 4'b0000; wait_cyc(5);
        chk(cnt_val == 1, "R3 trigger falling edge ignored", cnt_val, 1);
        slave_mode = 3'd7; trig_sel = 3'd0;
        restart();
        cnt_en = 1'b1;
        itrig_in = 4'b0001; wait_cyc(5);
        itrig_in = 4'b0000; wait_cyc(5);
        chk(cnt_val == 1, "R3 trigger 0 in mode 7", cnt_val, 1);
    endtask

    task automatic t_ch0_both();
        slave_mode = 3'd7; trig_sel = 3'd4;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1; wait_cyc(5);
        ch0_in = 1'b0; wait_cyc(5);
        chk(cnt_val == 2, "R4 channel 0 both edges", cnt_val, 2);
    endtask

    task automatic t_polarity();
        slave_mode = 3'd7; trig_sel = 3'd5; ch0_pol = 1'b0;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1; wait_cyc(5);
        chk(cnt_val == 1, "R5 ch0 rising selected", cnt_val, 1);
        ch0_in = 1'b0; wait_cyc(5);
        chk(cnt_val == 1, "R5 ch0 falling ignored", cnt_val, 1);
        ch0_pol = 1'b1;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1; wait_cyc(5);
        chk(cnt_val == 0, "R5 ch0 rising ignored", cnt_val, 0);
        ch0_in = 1'b0; wait_cyc(5);
        chk(cnt_val == 1, "R5 ch0 falling selected", cnt_val, 1);
        trig_sel = 3'd6; ch1_pol = 1'b1; ch0_pol = 1'b0;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1; wait_cyc(5);
        ch0_in = 1'b0; wait_cyc(5);
        ch1_in = 1'b1; wait_cyc(5);
        chk(cnt_val == 0, "R5 ch1 rising ignored, ch0 ignored", cnt_val, 0);
        ch1_in = 1'b0; wait_cyc(5);
        chk(cnt_val == 1, "R5 ch1 falling selected", cnt_val, 1);
    endtask

    task automatic t_none();
        slave_mode = 3'd7; trig_sel = 3'd7;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1; ch1_in = 1'b1; itrig_in = 4'hF; wait_cyc(5);
        ch0_in = 1'b0; ch1_in = 1'b0; itrig_in = 4'h0; wait_cyc(5);
        chk(cnt_val == 0, "R6 no source", cnt_val, 0);
    endtask

    task automatic t_latency();
        slave_mode = 3'd7; trig_sel = 3'd4;
        restart();
        cnt_en = 1'b1;
        ch0_in = 1'b1;
        wait_cyc(2);
        chk(cnt_val == 0, "R7 not yet at second edge", cnt_val, 0);
        wait_cyc(1);
        chk(cnt_val == 1, "R7 counted at third edge", cnt_val, 1);
        ch0_in = 1'b0; wait_cyc(5);
    endtask

    task automatic t_enable();
        slave_mode = 3'd0;
        restart();
        cnt_en = 1'b0;
        wait_cyc(6);
        chk(cnt_val == 0, "R8 disabled holds", cnt_val, 0);
        chk(cnt_tick == 0, "R8 no strobe", cnt_tick, 0);
    endtask

    task automatic t_prescale_shadow();
        slave_mode = 3'd0; psc_val = 16'd2;
        restart();
        cnt_en = 1'b1;
        wait_cyc(8);
        chk(cnt_val == 2, "R9 divide by 3 after 8", cnt_val, 2);
        wait_cyc(1);
        chk(cnt_val == 3, "R9 divide by 3 after 9", cnt_val, 3);
        psc_val = 16'd0;
        wait_cyc(6);
        chk(cnt_val == 5, "R10 old prescaler kept", cnt_val, 5);
        restart();
        cnt_en = 1'b1;
        wait_cyc(4);
        chk(cnt_val == 4, "R10 new prescaler after update", cnt_val, 4);
    endtask

    task automatic t_wrap();
        slave_mode = 3'd0; psc_val = 0; reload_val = 16'd3;
        restart();
        cnt_en = 1'b1;
        wait_cyc(3);
        chk(cnt_val == 3, "R11 at reload", cnt_val, 3);
        chk(upd_evt == 0, "R11 no event before wrap", upd_evt, 0);
        wait_cyc(1);
        chk(cnt_val == 0, "R11 wrapped", cnt_val, 0);
        chk(upd_evt == 1, "R11 event raised", upd_evt, 1);
        wait_cyc(1);
        chk(cnt_val == 1, "R11 counting on", cnt_val, 1);
        chk(upd_evt == 0, "R11 event one cycle", upd_evt, 0);
        reload_val = 16'd1000;
    endtask

    task automatic t_upd_gen();
        slave_mode = 3'd0; psc_val = 0;
        restart();
        cnt_en = 1'b1;
        wait_cyc(7);
        chk(cnt_val == 7, "R12 before request", cnt_val, 7);
        upd_gen = 1'b1;
        wait_cyc(1);
        upd_gen = 1'b0;
        chk(cnt_val == 0, "R12 cleared", cnt_val, 0);
        chk(upd_evt == 1, "R12 event raised", upd_evt, 1);
        wait_cyc(1);
        chk(cnt_val == 1, "R12 resumes", cnt_val, 1);
        chk(upd_evt == 0, "R12 event one cycle", upd_evt, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_internal();
        t_forced_internal();
        t_itrig();
        t_ch0_both();
        t_polarity();
        t_none();
        t_latency();
        t_enable();
        t_prescale_shadow();
        t_wrap();
        t_upd_gen();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule